// File: doc/BRIEF.md
# Masked Interrupt Hub with Mode Register

This block gathers six interrupt sources into one interrupt line for the processor. Five sources are level signals that the pending word shows exactly as they arrive. The sixth source gives short pulses. The hub catches each rising edge of that input in a local sticky flag. Software clears the flag through a command bit in the mode register.

Each source has an enable mask. A mask is changed only through a pair of command bits, one that clears it and one that sets it. This lets software change one mask without a read-modify-write. The interrupt output is the registered OR of every pending bit that is enabled.

The same register port also holds a mode register. It has a 7-bit length field and three flags, and each flag has its own clear/set command pair. A read-only identification word completes the map. Software reaches all four words through a simple strobe bus with a 2-bit word index and 32-bit data. Read data is registered.

Top module: `irq_hub`

## Requirements
- R1: A read of word index 2 returns the pending word. Bits 4:0 equal `src_lvl[4:0]` as sampled in the read cycle, bit 5 is the sticky flag of the pulse source, and bits 31:6 are zero.
- R2: A write to word index 3 changes the masks. For source n (0..5), data bit 2n clears mask n and bit 2n+1 sets it. A read of word index 3 returns the masks in bits 5:0, in the same order as the pending word, with zeros above.
- R3: If a mask write has both bits of a pair at 1, or both at 0, that mask keeps its value.
- R4: `irq` is 1 in the cycle after a clock edge at which some pending bit and its mask bit were both 1. Otherwise it is 0.
- R5: A rising edge on `src_pulse` sets pending bit 5. The bit stays set until a write to word index 0 with data bit 11 at 1. If a rising edge and such a write fall in the same cycle, the bit stays set.
- R6: A write to word index 0 always loads data bits 6:0 into the length field. Bit pairs (7 clear, 8 set), (9 clear, 10 set) and (12 clear, 13 set) control flags A, B and C, with the same both-bits rule as R3. A read of word index 0 returns the length in bits 6:0, flag A in bit 7, flag B in bit 8 and flag C in bit 9, with zeros above.
- R7: A read of word index 1 returns the identification word. With the default parameters it is 0x02010202: bits 7:0 = 2, bits 15:8 = 2, bits 23:16 = 1, bits 31:24 = 2.
- R8: Reset sets to zero all masks, the sticky flag, the length field, the three flags, `irq` and `rdata`.
- R9: `rdata` takes its new value at the clock edge where `rd_en` is 1. It shows the state from before any write in that same cycle, and it holds its value while `rd_en` is 0.
- R10: Writes to word indices 1 and 2 change nothing that can be read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| src_lvl | input | 5 | Level interrupt sources 0..4 |
| src_pulse | input | 1 | Pulse interrupt source 5 (edge captured) |
| irq | output | 1 | Combined interrupt to the processor |

## Verification
If a mask bit is wrong inside the block, `irq` shows it one edge after the matching source goes active. It also shows in the next read of word index 3. If the sticky flag is lost or stuck, it shows in the pending word and in `irq` within one cycle. The bench drives edges on `src_pulse` that land on the same cycle as clear commands, because that is where the set-over-clear priority could go wrong. A wrong mode flag is only visible through a read of word index 0, so the bench reads that word after every mode write pattern, including the both-bits case.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    OFS_MODE = 2'd0,
    OFS_ID   = 2'd1,
    OFS_PEND = 2'd2,
    OFS_MASK = 2'd3
  } ofs_e;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned NSRC = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [2*NSRC-1:0] cmd,
  output logic [NSRC-1:0]   mask_q
);
  for (genvar n = 0; n < NSRC; n++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[n] <= 1'b0;
      end else if (wr) begin
        case (cmd[2*n+1 -: 2])
          2'b01:   mask_q[n] <= 1'b0;
          2'b10:   mask_q[n] <= 1'b1;
          default: mask_q[n] <= mask_q[n];
        endcase
      end
    end
  end

  // R3
  both_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && cmd[1:0] == 2'b11) |=> $stable(mask_q[0]));
  // R2
  set_only_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && cmd[1:0] == 2'b10) |=> mask_q[0]);
  // R2
  clr_only_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && cmd[1:0] == 2'b01) |=> !mask_q[0]);
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
  parameter int unsigned N_LVL = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_LVL-1:0] lvl,
  input  logic           pulse,
  input  logic           clr,
  output logic [N_LVL:0] pend
);
  logic prev_q;
  logic stick_q;
  logic rise;

  assign rise = pulse & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      stick_q <= 1'b0;
    end else begin
      prev_q <= pulse;
      if (rise)     stick_q <= 1'b1;
      else if (clr) stick_q <= 1'b0;
    end
  end

  assign pend = {stick_q, lvl};

  // R5
  rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |=> stick_q);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stick_q && !clr) |=> stick_q);
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !pulse) |=> !stick_q);
endmodule

// File: rtl/irq_mode_reg.sv
module irq_mode_reg #(
  parameter int unsigned LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [13:0]      cmd,
  output logic [LEN_W-1:0] len_q,
  output logic [2:0]       flag_q,
  output logic             clr_src
);
  localparam int unsigned NFLAG = 3;
  localparam int unsigned CLR_BIT = 11;
  localparam int CLR_POS [NFLAG] = '{7, 9, 12};

  always_ff @(posedge clk) begin
    if (rst)     len_q <= '0;
    else if (wr) len_q <= cmd[LEN_W-1:0];
  end

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[f] <= 1'b0;
      end else if (wr) begin
        case ({cmd[CLR_POS[f]+1], cmd[CLR_POS[f]]})
          2'b01:   flag_q[f] <= 1'b0;
          2'b10:   flag_q[f] <= 1'b1;
          default: flag_q[f] <= flag_q[f];
        endcase
      end
    end
  end

  assign clr_src = wr & cmd[CLR_BIT];

  // R6
  len_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> len_q == $past(cmd[LEN_W-1:0]));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(flag_q));
endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int unsigned N_LVL = 5,
  parameter int unsigned LEN_W = 7,
  parameter logic [7:0]  ID_B0 = 8'h02,
  parameter logic [7:0]  ID_B1 = 8'h02,
  parameter logic [7:0]  ID_B2 = 8'h01,
  parameter logic [7:0]  ID_B3 = 8'h02
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [4:0]  src_lvl,
  input  logic        src_pulse,
  output logic        irq
);
  import irq_hub_pkg::*;
  localparam int unsigned NSRC = N_LVL + 1;

  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  mask;
  logic [LEN_W-1:0] len;
  logic [2:0]       flags;
  logic             clr_src;
  logic             wr_mode, wr_mask;
  logic [31:0]      rd_mux;
  logic             unused_hi;

  assign unused_hi = ^wdata[31:14];
  assign wr_mode = wr_en && (addr == OFS_MODE);
  assign wr_mask = wr_en && (addr == OFS_MASK);

  irq_pend_unit #(.N_LVL(N_LVL)) u_pend (
    .clk(clk), .rst(rst), .lvl(src_lvl[N_LVL-1:0]), .pulse(src_pulse),
    .clr(clr_src), .pend(pend)
  );

  irq_mask_reg #(.NSRC(NSRC)) u_mask (
    .clk(clk), .rst(rst), .wr(wr_mask), .cmd(wdata[2*NSRC-1:0]), .mask_q(mask)
  );

  irq_mode_reg #(.LEN_W(LEN_W)) u_mode (
    .clk(clk), .rst(rst), .wr(wr_mode), .cmd(wdata[13:0]),
    .len_q(len), .flag_q(flags), .clr_src(clr_src)
  );

  always_comb begin
    unique case (ofs_e'(addr))
      OFS_MODE: rd_mux = {{(DATA_W-LEN_W-3){1'b0}}, flags, len};
      OFS_ID:   rd_mux = {ID_B3, ID_B2, ID_B1, ID_B0};
      OFS_PEND: rd_mux = {{(DATA_W-NSRC){1'b0}}, pend};
      default:  rd_mux = {{(DATA_W-NSRC){1'b0}}, mask};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq <= |(pend & mask);
    end
  end

  // R4
  irq_on_chk: assert property (@(posedge clk) disable iff (rst)
    (|(pend & mask)) |=> irq);
  // R4
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(pend & mask)) |=> !irq);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/irq_hub_tb.sv
module irq_hub_tb;
  localparam int CLK_P = 10;
  localparam int WDOG = 20000;

  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0, rd_en = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [4:0]  src_lvl = 0;
  logic        src_pulse = 0;
  logic        irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_hub u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_lvl(src_lvl), .src_pulse(src_pulse),
    .irq(irq)
  );

  // behavioural reference
  int m_mask, m_p5, m_prev, m_len, m_fa, m_fb, m_fc, m_irq, m_raddr;
  logic [31:0] m_rdata;

  function automatic int pair_upd(int cur, int clrb, int setb);
    if (setb == 1 && clrb == 0) return 1;
    if (clrb == 1 && setb == 0) return 0;
    return cur;
  endfunction

  always @(posedge clk) begin
    int pend;
    if (rst) begin
      m_mask = 0; m_p5 = 0; m_prev = 0; m_len = 0;
      m_fa = 0; m_fb = 0; m_fc = 0; m_irq = 0; m_rdata = 0; m_raddr = 0;
    end else begin
      pend = int'(src_lvl) + m_p5 * 32;
      if (rd_en) begin
        m_raddr = int'(addr);
        case (addr)
          2'd0: m_rdata = m_len + m_fa * 128 + m_fb * 256 + m_fc * 512;
          2'd1: m_rdata = 32'h02010202;
          2'd2: m_rdata = pend;
          default: m_rdata = m_mask;
        endcase
      end
      m_irq = ((pend & m_mask) != 0) ? 1 : 0;
      if (wr_en && addr == 2'd3)
        for (int n = 0; n < 6; n++)
          if (pair_upd((m_mask >> n) & 1, wdata[2*n], wdata[2*n+1]))
            m_mask = m_mask | (1 << n);
          else
            m_mask = m_mask & ~(1 << n);
      if (src_pulse && m_prev == 0) m_p5 = 1;
      else if (wr_en && addr == 2'd0 && wdata[11]) m_p5 = 0;
      m_prev = src_pulse;
      if (wr_en && addr == 2'd0) begin
        m_len = int'(wdata[6:0]);
        m_fa = pair_upd(m_fa, wdata[7], wdata[8]);
        m_fb = pair_upd(m_fb, wdata[9], wdata[10]);
        m_fc = pair_upd(m_fc, wdata[12], wdata[13]);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    string t;
    if (!rst && !done) begin
      chk("R4 irq vs model", {31'b0, irq}, m_irq);
      case (m_raddr)
        0: t = "R6 rdata vs model";
        1: t = "R7 rdata vs model";
        2: t = "R1 rdata vs model";
        default: t = "R2 rdata vs model";
      endcase
      chk(t, rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected < %0d", cyc, WDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #1 wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd_exp(logic [1:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1 rd_en = 1; addr = a;
    @(posedge clk); #1 rd_en = 0;
    chk(tag, rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    idle(3);
    chk("R8 irq after reset", {31'b0, irq}, 0);
    chk("R8 rdata after reset", rdata, 0);
    rst = 0;
    rd_exp(2'd0, 32'h0, "R8 mode reset");
    rd_exp(2'd3, 32'h0, "R8 mask reset");
    rd_exp(2'd2, 32'h0, "R8 pending reset");
    rd_exp(2'd1, 32'h02010202, "R7 id word");

    src_lvl = 5'b10101;
    rd_exp(2'd2, 32'h15, "R1 level pattern");
    chk("R4 masked off", {31'b0, irq}, 0);
    wr(2'd3, 32'hAAA);
    rd_exp(2'd3, 32'h3F, "R2 set all");
    chk("R4 irq raised", {31'b0, irq}, 1);
    wr(2'd3, 32'hFFF);
    rd_exp(2'd3, 32'h3F, "R3 both bits keep");
    wr(2'd3, 32'h005);
    rd_exp(2'd3, 32'h3C, "R2 clear src0 src1");
    src_lvl = 5'b00011;
    idle(2);
    chk("R4 only masked sources", {31'b0, irq}, 0);
    src_lvl = 5'b01010;
    rd_exp(2'd2, 32'h0A, "R1 level pattern 2");
    src_lvl = 0;

    @(posedge clk); #1 src_pulse = 1;
    @(posedge clk); #1 src_pulse = 0;
    rd_exp(2'd2, 32'h20, "R5 pulse latched");
    idle(4);
    rd_exp(2'd2, 32'h20, "R5 pulse held");
    chk("R4 irq from sticky", {31'b0, irq}, 1);
    wr(2'd0, 32'h800);
    rd_exp(2'd2, 32'h0, "R5 cleared by mode bit");
    @(posedge clk); #1 src_pulse = 1; wr_en = 1; addr = 2'd0; wdata = 32'h800;
    @(posedge clk); #1 src_pulse = 0; wr_en = 0;
    rd_exp(2'd2, 32'h20, "R5 rise beats clear");
    wr(2'd0, 32'h800);

    wr(2'd0, 32'h2555);
    rd_exp(2'd0, 32'h3D5, "R6 set flags len");
    wr(2'd0, 32'h180);
    rd_exp(2'd0, 32'h380, "R6 both bits keep");
    wr(2'd0, 32'h1200);
    rd_exp(2'd0, 32'h080, "R6 clear two flags");

    @(posedge clk); #1 src_pulse = 1;
    @(posedge clk); #1 src_pulse = 0;
    wr(2'd1, 32'hFFFF_FFFF);
    rd_exp(2'd1, 32'h02010202, "R10 id write ignored");
    wr(2'd2, 32'h0);
    rd_exp(2'd2, 32'h20, "R10 pending write ignored");

    @(posedge clk); #1 rd_en = 1; wr_en = 1; addr = 2'd3; wdata = 32'h002;
    @(posedge clk); #1 rd_en = 0; wr_en = 0;
    chk("R9 read sees old state", rdata, 32'h3C);
    idle(3);
    chk("R9 rdata held", rdata, 32'h3C);
    rd_exp(2'd3, 32'h3D, "R9 new state next read");

    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule